// File: doc/BRIEF.md
# Buffered I2C Transfer Sequencer

This block runs a complete I2C transfer on its own, using a small local byte buffer. It sits between a host and a byte-level I2C master engine. The host fills the buffer while the block is idle. Byte 0 holds the 7-bit device address shifted left by one, with bit 0 set for a read and clear for a write. For a write, zero to two register-address bytes come next (most significant byte first), then the payload. The host gives the lengths and pulses `go_i`.

From then on the sequencer answers each event code from the engine with one command. The command sends the next buffer byte, acknowledges or refuses a received byte, or ends the transfer with a STOP. Received bytes are stored from buffer index 1 upward. The outcome is kept in a status byte with these flags: busy, timeout, start sent, address acknowledged, data acknowledged and complete.

A register read is two transfers. First a write carrying only the register address, then a read that begins with a fresh START. A cycle-count watchdog abandons any transfer that does not finish in time.

Top module: `i2c_buf_seq`

## Requirements
- R1: After reset the status byte is 0x00, the index is 0 and no command is issued.
- R2: The status byte has these bits: 7 busy, 6 timeout, 3 start sent, 2 address acknowledged, 1 data acknowledged, 0 complete. An accepted `go_i` in idle sets the status to 0x80, resets the timeout counter and issues command START (0) one cycle later.
- R3: A request is rejected, with no command issued and the status unchanged, in these cases. For a write, if `addr_len_i` is 3 or if 1 + `addr_len_i` + `data_len_i` exceeds DEPTH. For a read, if `data_len_i` is 0 or if 1 + `data_len_i` exceeds DEPTH.
- R4: Event START (0) sets the status to 0x88 and the index to 1, and issues TX (1) carrying buffer byte 0.
- R5: In a write, event ADDR_ACK (1) sets bit 2 and event DATA_ACK (3) sets bit 1. After either one, the next buffer byte is sent while the index is below 1 + address length + payload length. Otherwise bit 0 is set and STOP (4) is issued.
- R6: Event ADDR_NACK (2) issues STOP without setting the complete flag.
- R7: In a write, event DATA_NACK (4) sets bit 0 and issues STOP at once.
- R8: In a read of N bytes, bytes 1 to N-1 are answered with RX_ACK (2) and byte N with RX_NACK (3). Event RX_ACKED (5) stores the byte at the index, advances the index and sets bit 1. Event RX_NACKED (6) stores the byte, sets bits 2, 1 and 0, and issues STOP. The received count output equals the index minus one.
- R9: Event STOP_DONE (7) after a STOP clears the busy bit and returns the block to idle.
- R10: If a transfer is still busy TMO_CYCLES cycles after it was accepted, bit 6 is set, busy is cleared and STOP is issued. Later events are then ignored.
- R11: Engine events while idle, `go_i` while busy, and host buffer writes while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host buffer write strobe (idle only) |
| host_addr_i | input | AW | Host buffer write index |
| host_wdata_i | input | 8 | Host buffer write data |
| host_raddr_i | input | AW | Host buffer read index |
| host_rdata_o | output | 8 | Host buffer read data |
| addr_len_i | input | 2 | Register-address byte count for a write |
| data_len_i | input | IW | Payload length for a write, receive length for a read |
| go_i | input | 1 | Start a transfer |
| ev_valid_i | input | 1 | Engine event strobe |
| ev_code_i | input | 3 | Engine event code |
| ev_data_i | input | 8 | Received byte for RX events |
| cmd_valid_o | output | 1 | Command strobe to engine |
| cmd_o | output | 3 | Command code |
| tx_data_o | output | 8 | Byte to send with TX |
| status_o | output | 8 | Status byte |
| index_o | output | IW | Current buffer index |
| rx_count_o | output | IW | Bytes received (index minus one) |

## Verification
The bench attacks the length edges in both directions. These are a write of exactly DEPTH bytes, an address-only write, a one-byte read, and requests one byte over the limit. An off-by-one compare would send one byte too many or too few, or accept an oversized request. It sends a NACK on the address and a NACK in the middle of the data. A design that mixed these up would flag completion after an address refusal, or keep sending after a data refusal. It also sends traffic that must be ignored: host writes and a second `go_i` during a transfer, and events after a timeout. A leaky design would corrupt received data, restart the transfer, or revive a transfer it had already abandoned.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    EV_START     = 3'd0,
    EV_ADDR_ACK  = 3'd1,
    EV_ADDR_NACK = 3'd2,
    EV_DATA_ACK  = 3'd3,
    EV_DATA_NACK = 3'd4,
    EV_RX_ACKED  = 3'd5,
    EV_RX_NACKED = 3'd6,
    EV_STOP_DONE = 3'd7
  } ev_e;

  typedef enum logic [2:0] {
    CMD_START  = 3'd0,
    CMD_TX     = 3'd1,
    CMD_RX_ACK = 3'd2,
    CMD_RX_NAK = 3'd3,
    CMD_STOP   = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_STOP = 2'd2
  } sq_e;

  localparam int unsigned B_BUSY  = 7;
  localparam int unsigned B_TMO   = 6;
  localparam int unsigned B_START = 3;
  localparam int unsigned B_AACK  = 2;
  localparam int unsigned B_DACK  = 1;
  localparam int unsigned B_DONE  = 0;
endpackage

// File: rtl/seq_buf.sv
module seq_buf #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] ra_i,
  output logic [7:0]    rd_a_o,
  input  logic [AW-1:0] rb_i,
  output logic [7:0]    rd_b_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rd_a_o = mem_q[ra_i];
  assign rd_b_o = mem_q[rb_i];
endmodule

// File: rtl/seq_tmo.sv
module seq_tmo #(
  parameter int unsigned LIMIT = 3750000,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic hit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (hit_o)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/i2c_buf_seq.sv
module i2c_buf_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TMO_CYCLES = 3750000,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned IW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  input  logic [AW-1:0] host_raddr_i,
  output logic [7:0]    host_rdata_o,
  input  logic [1:0]    addr_len_i,
  input  logic [IW-1:0] data_len_i,
  input  logic          go_i,
  input  logic          ev_valid_i,
  input  logic [2:0]    ev_code_i,
  input  logic [7:0]    ev_data_i,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_o,
  output logic [7:0]    tx_data_o,
  output logic [7:0]    status_o,
  output logic [IW-1:0] index_o,
  output logic [IW-1:0] rx_count_o
);
  localparam int unsigned SW = IW + 2;

  sq_e           state_q;
  cmd_e          cmd_q;
  logic          cmd_valid_q;
  logic [7:0]    tx_q, status_q;
  logic [IW-1:0] idx_q, limit_q;
  logic          rd_q;

  logic [AW-1:0] seq_raddr;
  logic [7:0]    seq_rdata;
  logic          seq_we, buf_we, tmo_hit, go_ok;
  logic [AW-1:0] buf_waddr;
  logic [7:0]    buf_wdata;
  logic [SW-1:0] wr_sum;
  logic          is_rd, req_ok, ev_start;

  // request check
  assign is_rd  = seq_rdata[0];
  assign wr_sum = SW'(1) + SW'(addr_len_i) + SW'(data_len_i);
  assign req_ok = is_rd ? (data_len_i != '0) && (SW'(data_len_i) + SW'(1) <= SW'(DEPTH))
                        : (addr_len_i != 2'd3) && (wr_sum <= SW'(DEPTH));
  assign go_ok  = (state_q == SQ_IDLE) && go_i && req_ok;

  assign ev_start  = ev_valid_i && (ev_code_i == EV_START);
  assign seq_raddr = (state_q == SQ_IDLE || ev_start) ? '0 : idx_q[AW-1:0];

  assign seq_we = (state_q == SQ_RUN) && ev_valid_i && !tmo_hit && rd_q &&
                  (ev_code_i == EV_RX_ACKED || ev_code_i == EV_RX_NACKED);
  assign buf_we    = seq_we || (host_we_i && state_q == SQ_IDLE);
  assign buf_waddr = seq_we ? idx_q[AW-1:0] : host_addr_i;
  assign buf_wdata = seq_we ? ev_data_i : host_wdata_i;

  seq_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (buf_wdata),
    .ra_i    (seq_raddr),
    .rd_a_o  (seq_rdata),
    .rb_i    (host_raddr_i),
    .rd_b_o  (host_rdata_o)
  );

  seq_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go_ok),
    .run_i  (state_q != SQ_IDLE),
    .hit_o  (tmo_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SQ_IDLE;
      cmd_q       <= CMD_START;
      cmd_valid_q <= 1'b0;
      tx_q        <= '0;
      status_q    <= '0;
      idx_q       <= '0;
      limit_q     <= '0;
      rd_q        <= 1'b0;
    end else begin
      cmd_valid_q <= 1'b0;
      if (state_q == SQ_IDLE) begin
        if (go_ok) begin
          state_q     <= SQ_RUN;
          status_q    <= 8'h80;
          idx_q       <= '0;
          rd_q        <= is_rd;
          limit_q     <= is_rd ? data_len_i : wr_sum[IW-1:0];
          cmd_q       <= CMD_START;
          cmd_valid_q <= 1'b1;
        end
      end else if (tmo_hit) begin
        status_q[B_TMO]  <= 1'b1;
        status_q[B_BUSY] <= 1'b0;
        state_q          <= SQ_IDLE;
        if (state_q == SQ_RUN) begin
          cmd_q       <= CMD_STOP;
          cmd_valid_q <= 1'b1;
        end
      end else if (ev_valid_i) begin
        if (state_q == SQ_STOP) begin
          if (ev_code_i == EV_STOP_DONE) begin
            status_q[B_BUSY] <= 1'b0;
            state_q          <= SQ_IDLE;
          end
        end else begin
          cmd_valid_q <= 1'b1;
          if (ev_code_i == EV_START) begin
            status_q <= 8'h88;
            idx_q    <= IW'(1);
            tx_q     <= seq_rdata;
            cmd_q    <= CMD_TX;
          end else if (rd_q && ev_code_i == EV_ADDR_ACK) begin
            status_q[B_AACK] <= 1'b1;
            idx_q            <= IW'(1);
            cmd_q            <= (IW'(1) < limit_q) ? CMD_RX_ACK : CMD_RX_NAK;
          end else if (rd_q && ev_code_i == EV_RX_ACKED) begin
            status_q[B_DACK] <= 1'b1;
            idx_q            <= idx_q + 1'b1;
            cmd_q            <= ((idx_q + 1'b1) < limit_q) ? CMD_RX_ACK : CMD_RX_NAK;
          end else if (rd_q && ev_code_i == EV_RX_NACKED) begin
            status_q[2:0] <= 3'b111;
            idx_q         <= idx_q + 1'b1;
            cmd_q         <= CMD_STOP;
            state_q       <= SQ_STOP;
          end else if (!rd_q && (ev_code_i == EV_ADDR_ACK || ev_code_i == EV_DATA_ACK)) begin
            if (ev_code_i == EV_ADDR_ACK) status_q[B_AACK] <= 1'b1;
            else                          status_q[B_DACK] <= 1'b1;
            if (idx_q < limit_q) begin
              tx_q  <= seq_rdata;
              idx_q <= idx_q + 1'b1;
              cmd_q <= CMD_TX;
            end else begin
              status_q[B_DONE] <= 1'b1;
              cmd_q            <= CMD_STOP;
              state_q          <= SQ_STOP;
            end
          end else if (!rd_q && ev_code_i == EV_DATA_NACK) begin
            status_q[B_DONE] <= 1'b1;
            cmd_q            <= CMD_STOP;
            state_q          <= SQ_STOP;
          end else begin
            // address refusal or out-of-order event: abort without done
            cmd_q   <= CMD_STOP;
            state_q <= SQ_STOP;
          end
        end
      end
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_q;
  assign tx_data_o   = tx_q;
  assign status_o    = status_q;
  assign index_o     = idx_q;
  assign rx_count_o  = (idx_q == '0) ? '0 : idx_q - 1'b1;

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_IDLE && !go_i) |=> !cmd_valid_o);

  assert_start_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RUN && ev_start && !tmo_hit) |=>
      (status_o == 8'h88 && index_o == IW'(1) && cmd_o == CMD_TX && cmd_valid_o));

  assert_wr_finish_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RUN && ev_valid_i && ev_code_i == EV_DATA_ACK && !rd_q &&
     idx_q >= limit_q && !tmo_hit) |=> (cmd_o == CMD_STOP && status_o[B_DONE]));

  assert_rx_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RUN && ev_valid_i && ev_code_i == EV_RX_NACKED && rd_q && !tmo_hit) |=>
      (status_o[2:0] == 3'b111 && cmd_o == CMD_STOP));

  assert_stop_clears_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_STOP && ev_valid_i && ev_code_i == EV_STOP_DONE && !tmo_hit) |=>
      !status_o[B_BUSY]);

  assert_tmo_abandon_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SQ_IDLE && tmo_hit) |=> (status_o[B_TMO] && !status_o[B_BUSY]));
endmodule

// File: tb/tb_i2c_buf_seq.sv
module tb_i2c_buf_seq;
  localparam int DEPTH = 16;
  localparam int TMO   = 60;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = $clog2(DEPTH + 1);

  // ev / cmd codes from the requirements
  localparam logic [2:0] E_START = 0, E_AACK = 1, E_ANAK = 2, E_DACK = 3,
                         E_DNAK = 4, E_RXA = 5, E_RXN = 6, E_SDONE = 7;
  localparam logic [2:0] C_START = 0, C_TX = 1, C_RXA = 2, C_RXN = 3, C_STOP = 4;

  // write vectors: {addr_len[11:10], payload_len[9:5], nack_at[4:0] (31 = none)}
  localparam logic [5:0][11:0] VECS = '{
    {2'd0, 5'd1,  5'd1},
    {2'd2, 5'd4,  5'd3},
    {2'd1, 5'd2,  5'd0},
    {2'd2, 5'd13, 5'd31},
    {2'd1, 5'd3,  5'd31},
    {2'd0, 5'd0,  5'd31}
  };

  logic          clk = 0, rst_n = 0;
  logic          host_we = 0, go = 0, ev_valid = 0;
  logic [AW-1:0] host_addr = '0, host_raddr = '0;
  logic [7:0]    host_wdata = '0, ev_data = '0;
  logic [1:0]    alen = '0;
  logic [IW-1:0] dlen = '0;
  logic [2:0]    ev_code = '0;
  logic [7:0]    host_rdata, tx_data, status;
  logic          cmd_valid;
  logic [2:0]    cmd;
  logic [IW-1:0] index, rx_count;
  int            n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  i2c_buf_seq #(.DEPTH(DEPTH), .TMO_CYCLES(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_raddr_i(host_raddr), .host_rdata_o(host_rdata),
    .addr_len_i(alen), .data_len_i(dlen), .go_i(go),
    .ev_valid_i(ev_valid), .ev_code_i(ev_code), .ev_data_i(ev_data),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .tx_data_o(tx_data),
    .status_o(status), .index_o(index), .rx_count_o(rx_count)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic hwrite(input int a, input logic [7:0] d);
    host_we = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic start_go(input logic [1:0] al, input int dl);
    alen = al; dlen = IW'(dl); go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic ev(input logic [2:0] c, input logic [7:0] d);
    ev_valid = 1; ev_code = c; ev_data = d;
    @(negedge clk); ev_valid = 0;
  endtask

  task automatic chk_cmd(input string req, input logic [2:0] exp);
    chk(cmd_valid && cmd == exp, req, {cmd_valid, cmd}, {1'b1, exp});
  endtask

  function automatic logic [7:0] pat(input int b, input int v);
    return (b == 0) ? 8'hA4 : 8'(b * 13 + v);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    logic [7:0] exp_st;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 8'h00 && index == '0 && !cmd_valid, "R1", status, 0);
    rst_n = 1;
    @(negedge clk);
    chk(status == 8'h00 && !cmd_valid, "R1", status, 0);

    // R11 event while idle ignored
    ev(E_START, 8'h00);
    chk(!cmd_valid && status == 8'h00, "R11", {cmd_valid, status}, 0);

    // write transfers from the vector table (R2, R4, R5, R6, R7, R9)
    for (int vi = 0; vi < 6; vi++) begin
      int al, pl, nk, tot;
      logic fin;
      al = int'(VECS[vi][11:10]); pl = int'(VECS[vi][9:5]); nk = int'(VECS[vi][4:0]);
      tot = 1 + al + pl;
      for (int b = 0; b < tot; b++) hwrite(b, pat(b, vi));
      start_go(al[1:0], pl);
      chk_cmd("R2", C_START);
      chk(status == 8'h80, "R2", status, 8'h80);
      ev(E_START, 8'h00);
      chk_cmd("R4", C_TX);
      chk(tx_data == pat(0, vi) && status == 8'h88 && index == IW'(1), "R4", tx_data, pat(0, vi));
      exp_st = 8'h88;
      fin = 0;
      for (int b = 0; b < tot && !fin; b++) begin
        if (nk == b) begin
          ev(b == 0 ? E_ANAK : E_DNAK, 8'h00);
          if (b > 0) exp_st[0] = 1;
          chk_cmd(b == 0 ? "R6" : "R7", C_STOP);
          chk(status == exp_st, b == 0 ? "R6" : "R7", status, exp_st);
          fin = 1;
        end else begin
          ev(b == 0 ? E_AACK : E_DACK, 8'h00);
          exp_st[b == 0 ? 2 : 1] = 1;
          if (b + 1 < tot) begin
            chk_cmd("R5", C_TX);
            chk(tx_data == pat(b + 1, vi), "R5", tx_data, pat(b + 1, vi));
          end else begin
            exp_st[0] = 1;
            chk_cmd("R5", C_STOP);
            fin = 1;
          end
          chk(status == exp_st, "R5", status, exp_st);
        end
      end
      ev(E_SDONE, 8'h00);
      chk(status == (exp_st & 8'h7F) && !cmd_valid, "R9", status, exp_st & 8'h7F);
    end

    // R3 rejected requests: status must stay as left by the last transfer
    exp_st = status;
    hwrite(0, 8'hA4);
    start_go(2'd3, 1);
    chk(!cmd_valid && status == exp_st, "R3", {cmd_valid, status}, exp_st);
    start_go(2'd2, 14);
    chk(!cmd_valid && status == exp_st, "R3", {cmd_valid, status}, exp_st);
    hwrite(0, 8'hA5);
    start_go(2'd0, 0);
    chk(!cmd_valid && status == exp_st, "R3", {cmd_valid, status}, exp_st);
    start_go(2'd0, 16);
    chk(!cmd_valid && status == exp_st, "R3", {cmd_valid, status}, exp_st);

    // R8 read of three bytes, with R11 host write and go during busy
    hwrite(5, 8'h55);
    start_go(2'd0, 3);
    chk_cmd("R2", C_START);
    hwrite(5, 8'hEE);
    start_go(2'd0, 3);
    chk(!cmd_valid && status == 8'h80, "R11", {cmd_valid, status}, 8'h80);
    ev(E_START, 8'h00);
    chk_cmd("R4", C_TX);
    chk(tx_data == 8'hA5, "R4", tx_data, 8'hA5);
    ev(E_AACK, 8'h00);
    chk_cmd("R8", C_RXA);
    chk(status == 8'h8C, "R8", status, 8'h8C);
    ev(E_RXA, 8'h11);
    chk_cmd("R8", C_RXA);
    chk(status == 8'h8E, "R8", status, 8'h8E);
    ev(E_RXA, 8'h22);
    chk_cmd("R8", C_RXN);
    ev(E_RXN, 8'h33);
    chk_cmd("R8", C_STOP);
    chk(status == 8'h8F && rx_count == IW'(3), "R8", {status, 3'(rx_count)}, {8'h8F, 3'd3});
    ev(E_SDONE, 8'h00);
    chk(status == 8'h0F, "R9", status, 8'h0F);
    for (int b = 1; b <= 3; b++) begin
      host_raddr = AW'(b); #1;
      chk(host_rdata == 8'(b * 8'h11), "R8", host_rdata, b * 8'h11);
    end
    host_raddr = AW'(5); #1;
    chk(host_rdata == 8'h55, "R11", host_rdata, 8'h55);
    @(negedge clk);

    // R8 single-byte read: first byte is refused
    start_go(2'd0, 1);
    ev(E_START, 8'h00);
    ev(E_AACK, 8'h00);
    chk_cmd("R8", C_RXN);
    ev(E_RXN, 8'h77);
    chk(status == 8'h8F && rx_count == IW'(1), "R8", status, 8'h8F);
    ev(E_SDONE, 8'h00);

    // R10 timeout after TMO cycles, later events ignored
    start_go(2'd0, 2);
    repeat (TMO - 1) @(negedge clk);
    chk(status == 8'h80, "R10", status, 8'h80);
    @(negedge clk);
    chk(status == 8'h40, "R10", status, 8'h40);
    chk_cmd("R10", C_STOP);
    ev(E_START, 8'h00);
    chk(!cmd_valid && status == 8'h40, "R10", {cmd_valid, status}, 8'h40);

    finish_run();
  end
endmodule